// File: doc/BRIEF.md
# Serial Shift-and-Store Register

This block takes a serial bit stream into a chain of edge-triggered shift stages. A level-sensitive storage register sits behind the chain, and its contents are presented on a parallel output bus. On every rising edge of the shift clock a new bit enters stage 0, and every other stage takes the bit held by the stage below it. While the strobe is high the storage register is transparent and follows the chain. When the strobe goes low the storage register freezes, so the parallel bus stays steady while new data is shifted in behind it.

The parallel bus is modelled as a data vector plus a per-bit drive-enable vector. When the output enable is low, every enable bit is low and the data bits read zero, which stands for a released, floating bus. The output enable never stops the shifting. Two cascade outputs let several blocks be chained. One carries the last stage and changes only on rising edges. The other re-times the last stage on the falling edge, which gives a following stage a full half period of margin. A synchronous active-high reset clears the chain, both cascade outputs and the storage register.

Top module: `shift_store_reg`

## Requirements
- R1: On each rising edge of `sclk` with `rst` low, `sdin` enters stage 0 and stage n takes the previous value of stage n-1.
- R2: While `strobe` is high, the storage register equals the shift stages, including across several rising edges, with stage n on bit n of `par_q`.
- R3: While `strobe` is low, the storage register keeps its value through any number of shifts.
- R4: When `oe` is low, `par_en` is all zeros and `par_q` is all zeros. When `oe` is high, `par_en` is all ones and `par_q` equals the storage register.
- R5: With `oe` low, rising edges still shift the chain and still update `casc_rise`.
- R6: After each rising edge, `casc_rise` equals the new value of the last stage, which is the value the second-to-last stage held before the edge.
- R7: On each falling edge of `sclk`, `casc_fall` takes the value of the last stage, and it holds that value across the following rising edge.
- R8: A falling edge changes neither `par_q` nor `casc_rise`.
- R9: While `rst` is high, the storage register reads zero. A rising edge with `rst` high clears every stage and `casc_rise`, and a falling edge with `rst` high clears `casc_fall`.
- R10: Two blocks chained through `casc_rise` deliver a 16-bit pattern intact after 16 rising edges. Two blocks chained through `casc_fall` do the same. In both chains the first block holds the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Shift clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| sdin | input | 1 | Serial data into stage 0 |
| strobe | input | 1 | High: storage register is transparent |
| oe | input | 1 | High: parallel bus is driven |
| par_q | output | STAGES | Parallel data from the storage register |
| par_en | output | STAGES | Per-bit drive enable for `par_q` |
| casc_rise | output | 1 | Last stage, updated on rising edges |
| casc_fall | output | 1 | Last stage, re-timed on falling edges |

## Verification
The bench holds the strobe low through several shifts. A storage stage built as an edge flop, or one clocked by the wrong signal, would let `par_q` move during that time. It also holds the strobe high through several clocks, where a latch that captures only on a strobe edge would leave `par_q` stale. With `oe` low it shifts and then raises the strobe. A design that gated the clock with the enable would show old contents at that point. It samples both cascade outputs just after each edge of both polarities: a `casc_fall` taken on the wrong edge shows up one half period early, and a `casc_rise` that lags by one stage corrupts the 16-bit patterns sent through the chained pairs.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    localparam int unsigned SSR_STAGES_DEFAULT = 8;

    typedef struct packed {
        logic on_rise;
        logic on_fall;
    } ssr_casc_t;

endpackage

// File: rtl/ssr_shift_chain.sv
module ssr_shift_chain #(
    parameter int unsigned STAGES = ssr_pkg::SSR_STAGES_DEFAULT
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              sdin,
    output logic [STAGES-1:0] stages
);
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic d_in;
        logic q_r;
        if (g == 0) begin : g_head
            assign d_in = sdin;
        end else begin : g_body
            assign d_in = stages[g-1];
        end
        always_ff @(posedge sclk) begin
            if (rst) q_r <= 1'b0;
            else     q_r <= d_in;
        end
        assign stages[g] = q_r;
    end
endmodule

// File: rtl/ssr_store_latch.sv
module ssr_store_latch #(
    parameter int unsigned STAGES = ssr_pkg::SSR_STAGES_DEFAULT
) (
    input  logic              rst,
    input  logic              strobe,
    input  logic [STAGES-1:0] stages,
    output logic [STAGES-1:0] store
);
    for (genvar g = 0; g < STAGES; g++) begin : g_cell
        logic held;
        always_latch begin
            if (rst)         held <= 1'b0;
            else if (strobe) held <= stages[g];
        end
        assign store[g] = held;
    end
endmodule

// File: rtl/ssr_casc_taps.sv
module ssr_casc_taps (
    input  logic              sclk,
    input  logic              rst,
    input  logic              last_stage,
    output ssr_pkg::ssr_casc_t casc
);
    logic fall_r;

    always_ff @(negedge sclk) begin
        if (rst) fall_r <= 1'b0;
        else     fall_r <= last_stage;
    end

    assign casc.on_rise = last_stage;
    assign casc.on_fall = fall_r;
endmodule

// File: rtl/ssr_out_stage.sv
module ssr_out_stage #(
    parameter int unsigned STAGES = ssr_pkg::SSR_STAGES_DEFAULT
) (
    input  logic              oe,
    input  logic [STAGES-1:0] store,
    output logic [STAGES-1:0] par_q,
    output logic [STAGES-1:0] par_en
);
    for (genvar g = 0; g < STAGES; g++) begin : g_pad
        assign par_en[g] = oe;
        assign par_q[g]  = oe & store[g];
    end
endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg #(
    parameter int unsigned STAGES = ssr_pkg::SSR_STAGES_DEFAULT
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              sdin,
    input  logic              strobe,
    input  logic              oe,
    output logic [STAGES-1:0] par_q,
    output logic [STAGES-1:0] par_en,
    output logic              casc_rise,
    output logic              casc_fall
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0]  stages;
    logic [STAGES-1:0]  store;
    ssr_pkg::ssr_casc_t casc;

    ssr_shift_chain #(.STAGES(STAGES)) u_chain (
        .sclk   (sclk),
        .rst    (rst),
        .sdin   (sdin),
        .stages (stages)
    );

    ssr_store_latch #(.STAGES(STAGES)) u_latch (
        .rst    (rst),
        .strobe (strobe),
        .stages (stages),
        .store  (store)
    );

    ssr_casc_taps u_taps (
        .sclk       (sclk),
        .rst        (rst),
        .last_stage (stages[LAST]),
        .casc       (casc)
    );

    ssr_out_stage #(.STAGES(STAGES)) u_out (
        .oe     (oe),
        .store  (store),
        .par_q  (par_q),
        .par_en (par_en)
    );

    assign casc_rise = casc.on_rise;
    assign casc_fall = casc.on_fall;
endmodule

// File: rtl/ssr_chk.sv
module ssr_chk #(
    parameter int unsigned STAGES = ssr_pkg::SSR_STAGES_DEFAULT
) (
    input logic              sclk,
    input logic              rst,
    input logic              sdin,
    input logic              strobe,
    input logic [STAGES-1:0] stages,
    input logic [STAGES-1:0] store,
    input logic              casc_rise,
    input logic              casc_fall
);
    // R1: chain advances by one position per rising edge
    p_shift_r1: assert property (@(posedge sclk) disable iff (rst)
        1'b1 |=> stages == {$past(stages[STAGES-2:0]), $past(sdin)});

    // R2: transparent storage matches the chain
    p_track_r2: assert property (@(posedge sclk) disable iff (rst)
        strobe |-> store == stages);

    // R3: closed storage does not move
    p_hold_r3: assert property (@(posedge sclk) disable iff (rst)
        (!strobe && $past(!strobe)) |-> $stable(store));

    // R6: rising tap carries the bit from the stage below the last
    p_rise_r6: assert property (@(posedge sclk) disable iff (rst)
        1'b1 |=> casc_rise == $past(stages[STAGES-2]));

    // R7: falling tap re-times the rising tap by half a period
    p_fall_r7: assert property (@(negedge sclk) disable iff (rst)
        1'b1 |=> casc_fall == $past(casc_rise));
endmodule

bind shift_store_reg ssr_chk #(.STAGES(STAGES)) u_ssr_chk (
    .sclk      (sclk),
    .rst       (rst),
    .sdin      (sdin),
    .strobe    (strobe),
    .stages    (stages),
    .store     (store),
    .casc_rise (casc_rise),
    .casc_fall (casc_fall)
);

// File: tb/test_shift_store_reg.sv
module test_shift_store_reg;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst, sdin, strobe, oe, cdin;
    logic [N-1:0] par_q, par_en;
    logic casc_rise, casc_fall;

    logic [N-1:0] a0_q, a1_q, b0_q, b1_q, a0_e, a1_e, b0_e, b1_e;
    logic a0_r, a0_f, a1_r, a1_f, b0_r, b0_f, b1_r, b1_f;

    int checks = 0;
    int fails  = 0;

    logic [N-1:0] exp_stage, exp_store;
    logic exp_fall, cur_en;

    always #2 clk = ~clk;

    shift_store_reg #(.STAGES(N)) i_shift_store_reg (
        .sclk(clk), .rst(rst), .sdin(sdin), .strobe(strobe), .oe(oe),
        .par_q(par_q), .par_en(par_en), .casc_rise(casc_rise), .casc_fall(casc_fall));

    // R10: pair chained through the rising tap
    shift_store_reg #(.STAGES(N)) i_a0 (
        .sclk(clk), .rst(rst), .sdin(cdin), .strobe(1'b1), .oe(1'b1),
        .par_q(a0_q), .par_en(a0_e), .casc_rise(a0_r), .casc_fall(a0_f));
    shift_store_reg #(.STAGES(N)) i_a1 (
        .sclk(clk), .rst(rst), .sdin(a0_r), .strobe(1'b1), .oe(1'b1),
        .par_q(a1_q), .par_en(a1_e), .casc_rise(a1_r), .casc_fall(a1_f));
    // R10: pair chained through the falling tap
    shift_store_reg #(.STAGES(N)) i_b0 (
        .sclk(clk), .rst(rst), .sdin(cdin), .strobe(1'b1), .oe(1'b1),
        .par_q(b0_q), .par_en(b0_e), .casc_rise(b0_r), .casc_fall(b0_f));
    shift_store_reg #(.STAGES(N)) i_b1 (
        .sclk(clk), .rst(rst), .sdin(b0_f), .strobe(1'b1), .oe(1'b1),
        .par_q(b1_q), .par_en(b1_e), .casc_rise(b1_r), .casc_fall(b1_f));

    function automatic logic [N-1:0] bus_view(input logic en, input logic [N-1:0] st);
        return en ? st : '0;
    endfunction

    task automatic check_vec(input string tag, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic din, input logic stb, input logic en, input logic cd);
        @(negedge clk); #1;
        exp_fall = exp_stage[N-1];
        check_vec("R7 fall tap after falling edge", {15'd0, casc_fall}, {15'd0, exp_fall});
        check_vec("R8 par_q steady on falling edge", {8'd0, par_q}, {8'd0, bus_view(cur_en, exp_store)});
        check_vec("R8 casc_rise steady on falling edge", {15'd0, casc_rise}, {15'd0, exp_stage[N-1]});
        sdin = din; strobe = stb; oe = en; cdin = cd; cur_en = en;
        if (stb) exp_store = exp_stage;
        @(posedge clk);
        exp_stage = {exp_stage[N-2:0], din};
        if (stb) exp_store = exp_stage;
        #1;
        if (!en) begin
            check_vec("R4 bus released", {par_en, par_q}, 16'd0);
            check_vec("R5 casc_rise with oe low", {15'd0, casc_rise}, {15'd0, exp_stage[N-1]});
        end else begin
            check_vec(stb ? "R2 storage tracks chain" : "R3 storage held",
                      {8'd0, par_q}, {8'd0, exp_store});
            check_vec("R4 bus driven", {8'd0, par_en}, {8'd0, {N{1'b1}}});
            check_vec("R6 casc_rise after rising edge", {15'd0, casc_rise}, {15'd0, exp_stage[N-1]});
        end
        check_vec("R7 fall tap held over rising edge", {15'd0, casc_fall}, {15'd0, exp_fall});
    endtask

    task automatic send_pattern(input logic [2*N-1:0] pat);
        for (int i = 2*N-1; i >= 0; i--) step(1'b0, 1'b0, 1'b1, pat[i]);
        check_vec("R10 rise-tap chain", {a1_q, a0_q}, pat);
        check_vec("R10 fall-tap chain", {b1_q, b0_q}, pat);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        int seed;
        logic [N-1:0] pat8;
        seed = $urandom(32'h5EED_0042);
        rst = 1'b1; sdin = 1'b0; strobe = 1'b0; oe = 1'b1; cdin = 1'b0; cur_en = 1'b1;
        exp_stage = '0; exp_store = '0; exp_fall = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst = 1'b0;
        // R9: reset state
        check_vec("R9 reset par_q", {8'd0, par_q}, 16'd0);
        check_vec("R9 reset taps", {14'd0, casc_rise, casc_fall}, 16'd0);

        // R1/R2: known byte with storage open
        pat8 = 8'b1011_0010;
        for (int i = N-1; i >= 0; i--) step(pat8[i], 1'b1, 1'b1, 1'b0);
        check_vec("R1 byte shifted in", {8'd0, par_q}, {8'd0, pat8});

        // R3: storage closed while chain moves
        for (int i = 0; i < 5; i++) step(i[0], 1'b0, 1'b1, 1'b0);
        check_vec("R3 storage kept old byte", {8'd0, par_q}, {8'd0, pat8});

        // R4/R5: bus released, chain keeps shifting, then open storage
        for (int i = 0; i < 6; i++) step(~i[1], 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b1, 1'b0);
        check_vec("R5 shifts made while released are visible", {8'd0, par_q}, {8'd0, exp_stage});

        // random mix
        for (int i = 0; i < 200; i++)
            step(1'($urandom), ($urandom % 3) == 0, ($urandom % 4) != 0, 1'b0);

        // R10: cascaded pairs
        send_pattern(16'hA5C3);
        send_pattern(16'h0F71);
        send_pattern(16'($urandom));

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule